// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is one bank of general-purpose pins with a small word-addressed register interface. For each pin it holds an output value and an output enable, and it gives back a synchronized copy of the input level. Each pin also has its own interrupt detector. The detector can watch for an edge or for a level, and it can be set for either polarity. A detected event sets a sticky status bit, and software clears that bit by writing 1s to a separate clear register.

A single summary line, `irq_o`, is asserted while any pending bit is also enabled. The width of the bank is a parameter, because banks on one chip hold different numbers of pins. Only one edge direction can be selected per pin. To catch both edges, software rewrites the polarity bit to the inverse of the current input level each time an event is detected.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the output, output-enable, edge-select, enable and status registers are all zero, the polarity register is all ones, and `pin_o`, `pin_oe_o` and `irq_o` are low.
- R2: The register index on `addr_i` decodes as follows: 0 output value, 1 output enable, 2 input readback (read-only), 3 edge select, 4 polarity, 5 interrupt enable, 6 clear (write-only, reads 0), 7 status (read-only). `rdata_o` follows `addr_i` combinationally. A write with `wr_en_i` high takes effect at the next rising clock. Data bits at or above WIDTH read 0 and are ignored on writes.
- R3: `pin_o` equals the output-value register and `pin_oe_o` equals the output-enable register (1 drives the pin, 0 makes it an input).
- R4: A change on `pin_i` that is set up before a rising edge appears on readback index 2 after the second rising edge.
- R5: In edge mode (edge-select bit 1), a polarity bit of 1 detects a rising input and a polarity bit of 0 detects a falling input. The status bit sets at the third rising edge after the pin changes.
- R6: In level mode (edge-select bit 0), the status bit sets while the synchronized input equals the polarity bit. It stays set after the level goes away, until it is cleared.
- R7: Writing 1 to a bit of the clear register clears that status bit. Writing 0 leaves it unchanged. Writes to index 2 or index 7 change nothing.
- R8: If a detected event and a clear land on the same status bit in the same cycle, the bit stays set.
- R9: Status bits set whether or not the pin's interrupt is enabled. `irq_o` is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the register at `addr_i` |
| pin_i | input | WIDTH | Pin input levels |
| pin_o | output | WIDTH | Pin output values |
| pin_oe_o | output | WIDTH | Pin output enables |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench builds the bank with WIDTH = 20. This width is below the data bus, so the all-ones write exercises the rule that bits above the bank's width read zero and are ignored. It also leaves room for pins in all four detector modes (rising, falling, high level, low level) to be configured side by side. A behavioural model checks every clock, including a random phase that rewrites the mode registers while the pins toggle. Directed steps cover clear/event collisions, sticky level events and polarity flipping to catch both edges.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_OUT  = 3'd0,
    REG_OE   = 3'd1,
    REG_IN   = 3'd2,
    REG_EDGE = 3'd3,
    REG_POL  = 3'd4,
    REG_EN   = 3'd5,
    REG_CLR  = 3'd6,
    REG_STAT = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] edge_sel_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] event_w;
  logic [WIDTH-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic active_lvl, active_prev;
    // normalise to "active high" so one rule covers both polarities
    assign active_lvl  = ~(sync_i[b] ^ pol_i[b]);
    assign active_prev = ~(prev_q[b] ^ pol_i[b]);
    assign event_w[b]  = edge_sel_i[b] ? (active_lvl & ~active_prev) : active_lvl;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[b] <= 1'b0;
      else         status_q[b] <= (status_q[b] & ~clr_i[b]) | event_w[b];
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [WIDTH-1:0]  sync_i,
  input  logic [WIDTH-1:0]  status_i,
  output logic [WIDTH-1:0]  out_o,
  output logic [WIDTH-1:0]  oe_o,
  output logic [WIDTH-1:0]  edge_sel_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  en_o,
  output logic [WIDTH-1:0]  clr_o
);
  logic [WIDTH-1:0] wval;
  logic [WIDTH-1:0] rsel;
  logic unused_wdata;

  assign wval         = wdata_i[WIDTH-1:0];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o      <= '0;
      oe_o       <= '0;
      edge_sel_o <= '0;
      pol_o      <= '1;
      en_o       <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_OUT:  out_o      <= wval;
        REG_OE:   oe_o       <= wval;
        REG_EDGE: edge_sel_o <= wval;
        REG_POL:  pol_o      <= wval;
        REG_EN:   en_o       <= wval;
        default:  ;
      endcase
    end
  end

  assign clr_o = (wr_en_i && addr_i == REG_CLR) ? wval : '0;

  always_comb begin
    case (addr_i)
      REG_OUT:  rsel = out_o;
      REG_OE:   rsel = oe_o;
      REG_IN:   rsel = sync_i;
      REG_EDGE: rsel = edge_sel_o;
      REG_POL:  rsel = pol_o;
      REG_EN:   rsel = en_o;
      REG_STAT: rsel = status_i;
      default:  rsel = '0;
    endcase
    rdata_o = '0;
    rdata_o[WIDTH-1:0] = rsel;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] sync_w, status_q, edge_sel_w, pol_w, en_w, clr_w;

  gpio_irq_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  gpio_irq_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .sync_i    (sync_w),
    .status_i  (status_q),
    .out_o     (pin_o),
    .oe_o      (pin_oe_o),
    .edge_sel_o(edge_sel_w),
    .pol_o     (pol_w),
    .en_o      (en_w),
    .clr_o     (clr_w)
  );

  gpio_irq_detect #(.WIDTH(WIDTH)) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_w),
    .edge_sel_i(edge_sel_w),
    .pol_i     (pol_w),
    .clr_i     (clr_w),
    .status_o  (status_q)
  );

  assign irq_o = |(status_q & en_w);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [WIDTH-1:0]  pin_o,
  input logic [WIDTH-1:0]  pin_oe_o,
  input logic              irq_o,
  input logic [WIDTH-1:0]  status_i
);
  // R3
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == REG_OUT) |=> $stable(pin_o));

  // R3
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == REG_OE) |=> $stable(pin_oe_o));

  // R7
  clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == REG_CLR) |=> (($past(status_i) & ~status_i) == '0));

  // R9
  irq_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_i != '0));

  // R2
  clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_CLR) |-> (rdata_o == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .status_i(status_q)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
  localparam int W = 20;
  localparam logic [31:0] WMASK = (32'd1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [W-1:0] pin = '0;
  logic [W-1:0] pin_o, pin_oe;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.WIDTH(W)) u_gpio_irq_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // behavioural reference model
  logic [W-1:0] m_out, m_oe, m_edge, m_pol, m_en, m_stat;
  logic [W-1:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_oe = '0; m_edge = '0; m_pol = '1; m_en = '0; m_stat = '0;
      hist = '{'0, '0, '0};
    end else begin
      logic [W-1:0] ev, clr;
      for (int b = 0; b < W; b++) begin
        if (m_edge[b])
          ev[b] = m_pol[b] ? (hist[1][b] && !hist[2][b]) : (!hist[1][b] && hist[2][b]);
        else
          ev[b] = (hist[1][b] == m_pol[b]);
      end
      clr = (wr_en && addr == 3'd6) ? wdata[W-1:0] : '0;
      m_stat = (m_stat & ~clr) | ev;
      if (wr_en) begin
        case (addr)
          3'd0: m_out  = wdata[W-1:0];
          3'd1: m_oe   = wdata[W-1:0];
          3'd3: m_edge = wdata[W-1:0];
          3'd4: m_pol  = wdata[W-1:0];
          3'd5: m_en   = wdata[W-1:0];
          default: ;
        endcase
      end
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] m_read(logic [2:0] a);
    logic [W-1:0] v;
    case (a)
      3'd0: v = m_out;
      3'd1: v = m_oe;
      3'd2: v = hist[1];
      3'd3: v = m_edge;
      3'd4: v = m_pol;
      3'd5: v = m_en;
      3'd7: v = m_stat;
      default: v = '0;
    endcase
    return {{(32-W){1'b0}}, v};
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd2: return "R4";
      3'd6: return "R7";
      3'd7: return "R5/R6";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 pin_o", {{(32-W){1'b0}}, pin_o}, {{(32-W){1'b0}}, m_out});
      check("R3 pin_oe_o", {{(32-W){1'b0}}, pin_oe}, {{(32-W){1'b0}}, m_oe});
      check("R9 irq_o", {31'd0, irq}, {31'd0, |(m_stat & m_en)});
      check(tag_of(addr), rdata, m_read(addr));
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [31:0] mask, logic [31:0] exp, string req);
    @(negedge clk); #1;
    addr = a;
    #0.5;
    check(req, rdata & mask, exp);
  endtask

  task automatic set_pin(logic [W-1:0] v);
    @(negedge clk); #1;
    pin = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk(3'd0, '1, 32'd0, "R1 out");
    rd_chk(3'd1, '1, 32'd0, "R1 oe");
    rd_chk(3'd3, '1, 32'd0, "R1 edge");
    rd_chk(3'd4, '1, WMASK, "R1 pol");
    rd_chk(3'd5, '1, 32'd0, "R1 en");
    rd_chk(3'd7, '1, 32'd0, "R1 status");
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2/R3 output registers and upper bits
    wr(3'd0, 32'h000A5A5A);
    wr(3'd1, 32'h0000FF0F);
    rd_chk(3'd0, '1, 32'h000A5A5A, "R2 out");
    check("R3 pin_oe", {{(32-W){1'b0}}, pin_oe}, 32'h0000FF0F);
    wr(3'd0, 32'hFFFFFFFF);
    rd_chk(3'd0, '1, WMASK, "R2 upper bits");

    // R7 read-only registers ignore writes
    wr(3'd7, 32'hFFFFFFFF);
    wr(3'd2, 32'hFFFFFFFF);
    rd_chk(3'd7, '1, 32'd0, "R7 status write ignored");
    rd_chk(3'd2, '1, 32'd0, "R7 input write ignored");

    // modes: b0 rise, b1 fall, b2 level high, b3 level low
    wr(3'd3, 32'h00000003);
    wr(3'd4, 32'h000FFFF5);
    idle(3);
    // R8 level-low bit3 keeps firing while clear is written
    wr(3'd6, WMASK);
    rd_chk(3'd7, 32'hF, 32'h8, "R8 collision");

    set_pin(20'h0000B);
    idle(4);
    wr(3'd6, 32'h8);
    rd_chk(3'd7, 32'hF, 32'h1, "R5 rising");
    set_pin(20'h00009);
    idle(4);
    rd_chk(3'd7, 32'hF, 32'h3, "R5 falling");
    set_pin(20'h0000D);
    idle(4);
    set_pin(20'h00009);
    idle(4);
    rd_chk(3'd7, 32'hF, 32'h7, "R6 sticky level");

    // R9 enable gating
    check("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd5, 32'h4);
    check("R9 irq on", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'h4);
    check("R9 irq off after clear", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'h0);
    rd_chk(3'd7, 32'hF, 32'h3, "R7 zero write");

    // R5 both-edge emulation by polarity flip on bit0
    wr(3'd6, 32'h1);
    wr(3'd4, 32'h000FFFF4);
    set_pin(20'h00008);
    idle(4);
    rd_chk(3'd7, 32'h1, 32'h1, "R5 flipped polarity");

    // R4 two-stage readback latency
    set_pin(20'h05555);
    rd_chk(3'd2, WMASK, 32'h00008, "R4 one edge");
    rd_chk(3'd2, WMASK, 32'h05555, "R4 two edges");

    // random phase, model compared every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if ($urandom_range(0, 2) == 0) pin = W'($urandom);
      wr_en = ($urandom_range(0, 3) == 0);
      addr  = 3'($urandom_range(0, 7));
      wdata = $urandom;
    end
    @(negedge clk); #1 wr_en = 1'b0;
    idle(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule